// File: doc/BRIEF.md
# Errored Cell Insertion Controller

This block decides, cell by cell, whether the transmit cell path should deliberately corrupt the cell it is about to send. It is used for test: software programs how often a cell is damaged and how many damaged cells are wanted, and the cell path applies the corruption whenever the block raises its flag. A second, manual path lets an external test input force single errored cells.

The automatic path uses a rate code with a 4-bit mantissa and a 3-bit power-of-ten exponent, so the period is mantissa × 10^exponent cells. Every write to the control word discards the current run and starts a new one from cell zero. The manual path is a separate, edge-triggered path. It works alongside the automatic path and is not counted against the automatic burst length.

The cell path presents one `cell_start` strobe per cell. It cannot be held off: the block never applies back-pressure and has no ready signal. Its decision appears on `cell_err` as a one-cycle pulse in the cycle after the strobe.

Top module: `errcell_ctl`

## Requirements
- R1: After reset, `cell_err`, `busy` and `done` are 0, and the control word is zero, so neither insertion path is active.
- R2: The control word holds the manual enable in bit 15, the rate code in bits 14:8 and the burst count in bits 7:0. Rate bits 11:8 are the mantissa x and rate bits 14:12 are the exponent y. Counting cells from the last write, cell number k is errored when k is a multiple of x·10^y. Examples: code 01h errors every cell, 0Fh errors every 15th cell, 11h every 10th cell and 23h every 300th cell.
- R3: A mantissa of 0 disables automatic insertion for any exponent. In that case `busy` stays 0 after the write.
- R4: Once the number of automatically errored cells equals a burst count other than 0 and FFh, `busy` drops, `done` rises and no further automatic errors occur. `busy` and `done` are never both 1.
- R5: A burst count of FFh gives endless insertion at the programmed rate, and `done` never rises.
- R6: A burst count of 0 makes `done` 1 and `busy` 0 in the cycle after the write, and no automatic cell is errored.
- R7: A write during a run aborts the run and restarts period and burst counting from the new values.
- R8: With bit 15 set, a 0-to-1 transition of `man_err` errors the next cell. The input passes a two-flop synchronizer, so a transition seen at clock edge e can affect a `cell_start` sampled at edge e+2 or later. Several transitions before that cell merge into one errored cell.
- R9: With bit 15 clear, `man_err` has no effect and nothing is held pending.
- R10: Manual errors are combined with automatic ones by OR. They do not count toward the burst count and do not disturb the period.
- R11: `cell_err` is 1 only in the cycle after a `cell_start`, for one cycle.
- R12: Exponent codes 6 and 7 both give a period of x·10^6 cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word value |
| cell_start | input | 1 | One-cycle strobe per transmitted cell |
| man_err | input | 1 | Asynchronous manual error request |
| cell_err | output | 1 | Corrupt the cell strobed in the previous cycle |
| busy | output | 1 | Automatic run in progress |
| done | output | 1 | Automatic run reached its burst count |

## Verification
The assertions assume that `cell_start` is a single-cycle strobe and that `cfg_we` is never high in the same cycle as a `cell_start`. Under that assumption each cell belongs to exactly one run. The stimulus always leaves idle cycles between cells and places every write between cells. Manual pulses are held for several cycles so the synchronizer sees every level.

// File: rtl/errcell_pkg.sv
package errcell_pkg;
  localparam int CFG_W    = 16;
  localparam int MAN_BIT  = 15;
  localparam int EXP_HI   = 14;
  localparam int EXP_LO   = 12;
  localparam int MANT_HI  = 11;
  localparam int MANT_LO  = 8;
  localparam int CNT_HI   = 7;
  localparam int CNT_LO   = 0;
  localparam int MANT_W   = MANT_HI - MANT_LO + 1;
  localparam int EXP_W    = EXP_HI - EXP_LO + 1;
  localparam int CNT_W    = CNT_HI - CNT_LO + 1;

  typedef struct packed {
    logic              man_en;
    logic [EXP_W-1:0]  expo;
    logic [MANT_W-1:0] mant;
    logic [CNT_W-1:0]  burst;
  } ecfg_t;
endpackage

// File: rtl/errcell_sync_edge.sv
module errcell_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/errcell_rate_div.sv
module errcell_rate_div
  import errcell_pkg::*;
#(
  parameter int NDEC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  output logic              hit
);
  localparam int DW = 4;

  logic [MANT_W-1:0] mcnt_q;
  logic              m_term;
  logic [NDEC:0]     carry;
  int                exp_eff;

  always_comb begin
    exp_eff = (int'(expo) > NDEC) ? NDEC : int'(expo);
  end

  assign m_term   = (mcnt_q == MANT_W'(mant - MANT_W'(1)));
  assign carry[0] = m_term;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      mcnt_q <= '0;
    else if (adv)
      mcnt_q <= m_term ? '0 : MANT_W'(mcnt_q + MANT_W'(1));
  end

  for (genvar i = 0; i < NDEC; i++) begin : g_dec
    logic [DW-1:0] dcnt_q;
    logic          active;
    logic          wrap;

    assign active       = (exp_eff > i);
    assign wrap         = (dcnt_q == DW'(9));
    assign carry[i+1]   = carry[i] & (~active | wrap);

    always_ff @(posedge clk) begin
      if (!rst_n || clr)
        dcnt_q <= '0;
      else if (adv && active && carry[i])
        dcnt_q <= wrap ? '0 : DW'(dcnt_q + DW'(1));
    end
  end

  assign hit = carry[NDEC];
endmodule

// File: rtl/errcell_burst.sv
module errcell_burst
  import errcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             arm,
  input  logic [CNT_W-1:0] limit_new,
  input  logic [CNT_W-1:0] limit,
  input  logic             ev,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] ENDLESS = '1;

  logic [CNT_W-1:0] ecnt_q;
  logic [CNT_W-1:0] ecnt_nx;
  logic             last_one;

  assign ecnt_nx  = CNT_W'(ecnt_q + CNT_W'(1));
  assign last_one = (limit != ENDLESS) && (ecnt_nx == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecnt_q <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (load) begin
      ecnt_q <= '0;
      busy   <= arm && (limit_new != '0);
      done   <= (limit_new == '0);
    end else if (ev && busy) begin
      ecnt_q <= ecnt_nx;
      if (last_one) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/errcell_ctl.sv
module errcell_ctl
  import errcell_pkg::*;
#(
  parameter int NDEC      = 6,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cell_start,
  input  logic             man_err,
  output logic             cell_err,
  output logic             busy,
  output logic             done
);
  ecfg_t cfg_q;
  ecfg_t cfg_new;
  logic  man_rise;
  logic  pend_q;
  logic  rate_hit;
  logic  cell_ok;
  logic  auto_ev;
  logic  man_fire;

  assign cfg_new = ecfg_t'(cfg_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_new;
  end

  errcell_sync_edge #(.STAGES(SYNC_STGS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (man_err),
    .rise     (man_rise)
  );

  assign cell_ok = cell_start & ~cfg_we;

  errcell_rate_div #(.NDEC(NDEC)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_we),
    .adv   (cell_ok & busy),
    .mant  (cfg_q.mant),
    .expo  (cfg_q.expo),
    .hit   (rate_hit)
  );

  assign auto_ev = cell_ok & busy & rate_hit;

  errcell_burst u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_we),
    .arm       (cfg_new.mant != '0),
    .limit_new (cfg_new.burst),
    .limit     (cfg_q.burst),
    .ev        (auto_ev),
    .busy      (busy),
    .done      (done)
  );

  assign man_fire = cfg_q.man_en & (pend_q | man_rise);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (!cfg_q.man_en || (cfg_we && !cfg_new.man_en))
      pend_q <= 1'b0;
    else if (cell_start)
      pend_q <= 1'b0;
    else if (man_rise)
      pend_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cell_err <= 1'b0;
    else        cell_err <= cell_start & (auto_ev | man_fire);
  end
endmodule

// File: rtl/errcell_ctl_chk.sv
module errcell_ctl_chk
  import errcell_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [MANT_W-1:0] wr_mant,
  input logic [CNT_W-1:0]  wr_cnt,
  input logic              cell_start,
  input logic              cell_err,
  input logic              busy,
  input logic              done
);
  assert_err_after_cell_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cell_err |-> $past(cell_start));

  assert_not_busy_and_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_zero_count_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wr_cnt == '0) |=> (done && !busy));

  assert_zero_mant_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wr_mant == '0) |=> !busy);

  assert_run_end_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(cfg_we)) |-> done);
endmodule

bind errcell_ctl errcell_ctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .wr_mant    (cfg_wdata[11:8]),
  .wr_cnt     (cfg_wdata[7:0]),
  .cell_start (cell_start),
  .cell_err   (cell_err),
  .busy       (busy),
  .done       (done)
);

// File: tb/errcell_ctl_tb.sv
module errcell_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        cell_start = 1'b0;
  logic        man_err = 1'b0;
  logic        cell_err, busy, done;

  always #2 clk = ~clk;

  errcell_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cell_start(cell_start), .man_err(man_err),
    .cell_err(cell_err), .busy(busy), .done(done)
  );

  int    vectors = 0;
  int    fails = 0;
  int    cycles = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // behavioural reference state
  bit     m_err, m_busy, m_done, m_pend, m_en;
  int     m_x, m_y, m_cnt, m_idx, m_ecnt;
  longint m_per;
  bit     h0, h1, h2;

  always @(posedge clk) begin
    bit edge_now;
    bit hit;
    cycles++;
    if (!rst_n) begin
      m_err = 0; m_busy = 0; m_done = 0; m_pend = 0; m_en = 0;
      m_x = 0; m_y = 0; m_cnt = 0; m_idx = 0; m_ecnt = 0; m_per = 0;
      h0 = 0; h1 = 0; h2 = 0;
    end else begin
      edge_now = h1 && !h2;
      m_err = 0;
      if (cfg_we) begin
        m_en  = cfg_wdata[15];
        m_y   = cfg_wdata[14:12];
        m_x   = cfg_wdata[11:8];
        m_cnt = cfg_wdata[7:0];
        m_per = longint'(m_x) * (10 ** ((m_y > 6) ? 6 : m_y));
        m_idx = 0; m_ecnt = 0;
        m_busy = (m_x != 0) && (m_cnt != 0);
        m_done = (m_cnt == 0);
        if (!m_en) m_pend = 0;
      end else if (cell_start) begin
        hit = 0;
        if (m_busy) begin
          m_idx++;
          hit = (m_idx % m_per) == 0;
        end
        m_err = hit || (m_en && (m_pend || edge_now));
        m_pend = 0;
        if (hit) begin
          m_ecnt++;
          if (m_cnt != 255 && m_ecnt == m_cnt) begin
            m_busy = 0; m_done = 1;
          end
        end
      end else if (edge_now && m_en) begin
        m_pend = 1;
      end
      h2 = h1; h1 = h0; h0 = man_err;
    end
  end

  always @(negedge clk) begin
    if (!finished && cycles > 0) begin
      vectors++;
      if (cell_err !== m_err || busy !== m_busy || done !== m_done) begin
        fails++;
        $display("FAIL %s cycle %0d: err/busy/done actual %b%b%b expected %b%b%b",
                 cur_req, cycles, cell_err, busy, done, m_err, m_busy, m_done);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
    idle(1);
  endtask

  task automatic cells(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cell_start = 1'b1;
      @(negedge clk); cell_start = 1'b0;
    end
    idle(1);
  endtask

  task automatic man_pulse();
    @(negedge clk); man_err = 1'b1;
    idle(3);
    man_err = 1'b0;
    idle(3);
  endtask

  initial begin
    cur_req = "R1";
    idle(4);
    rst_n = 1'b1;
    idle(3);
    cells(5);
    man_pulse(); cells(2);

    cur_req = "R2";  wr(16'h01FF); cells(5);
    cur_req = "R2";  wr(16'h0FFF); cells(40);
    cur_req = "R2";  wr(16'h11FF); cells(35);
    cur_req = "R5";  wr(16'h23FF); cells(650);
    cur_req = "R12"; wr(16'h61FF); cells(300);
    cur_req = "R12"; wr(16'h71FF); cells(300);
    cur_req = "R3";  wr(16'h0005); cells(20);
    cur_req = "R3";  wr(16'h5005); cells(30);
    cur_req = "R4";  wr(16'h0303); cells(20);
    cur_req = "R6";  wr(16'h0200); cells(10);
    cur_req = "R7";  wr(16'h05FF); cells(3);
    cur_req = "R7";  wr(16'h05FF); cells(8);
    cur_req = "R7";  wr(16'h0202); cells(3);
    cur_req = "R8";  wr(16'h8000); man_pulse(); cells(3);
    cur_req = "R8";  man_pulse(); man_pulse(); cells(3);
    cur_req = "R9";  wr(16'h0000); man_pulse(); cells(3);
    cur_req = "R9";  man_pulse(); wr(16'h8000); cells(3);
    cur_req = "R10"; wr(16'h8402);
    for (int k = 0; k < 6; k++) begin
      man_pulse(); cells(3);
    end
    cells(6);
    cur_req = "R11"; wr(16'h82FF); cells(6); man_pulse(); cells(4);
    idle(5);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule